// File: doc/BRIEF.md
# Multi-Mode PWM Timer

This block is a timer whose counter runs between zero and a programmable upper limit and turns that count into pulse-width-modulated outputs. A single enable bit and a two-bit field choose one of five behaviours. With the enable clear it is a plain counter and the output pins carry a software-owned port value. With the enable set it runs as single-slope PWM, as dual-slope PWM, or as a six-pin variant of either slope in which one compare channel drives every pin.

The upper limit and every compare value are written into buffers. The active copies take the buffered values at a point in the period that depends on the mode, so a period never runs with a mix of old and new settings. A sticky overflow flag marks the end of each period. In the six-pin modes a per-pin override mask decides, on the cycle after it is written, whether each pin shows the waveform or its port bit. Software uses a simple write port and a combinational read port. The count, the flag and the pins are plain outputs.

Top module: `pwm_timer`

## Requirements
- R1: While the enable bit (bit 2 of the control register, address 0) is 0, the block behaves as a plain counter whatever the two-bit field holds. Every pin shows its bit of the port register (address 3).
- R2: With the enable set, the two-bit field (bits 1:0 of address 0) selects the mode: 00 single-slope PWM, 01 dual-slope PWM, 10 six-pin single-slope, 11 six-pin dual-slope.
- R3: In the three single-slope behaviours, the count rises by one each cycle. On the cycle after it reaches or exceeds the limit register (address 1), it returns to 0.
- R4: In the dual-slope modes, the count rises from 0 to the limit and then falls back to 0. Each end value lasts exactly one cycle, and a limit of 0 holds the count at 0.
- R5: Writes to the limit and to the compare registers (address 5+k for channel k) land in buffers. The active values follow the buffers on the next cycle in plain-counter mode. In modes 00 and 10 they reload on the clock edge that wraps the count. In the dual-slope modes they reload on the edge that leaves count 0.
- R6: The overflow flag is set on the edge at which the count wraps (single-slope) or leaves 0 (dual-slope). It stays set until a write of 1 to bit 0 of address 4 clears it; a set in the same cycle wins. It reads back at bit 0 of address 4.
- R7: In modes 00 and 01, pin 2k is high while the count is below the active compare value of channel k, and pin 2k+1 is its complement.
- R8: In modes 10 and 11, a pin whose override bit (address 2) is 1 shows the channel-0 waveform of R7, and a pin whose bit is 0 shows its port bit. A change of the mask is visible on the cycle after the write.
- R9: The override register reads back with bits 7:6 as 0.
- R10: After reset the count, the flag, every register and every pin are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky end-of-period flag |
| pins | output | 6 | Compare output pins |

## Verification
A wrong count or direction shows on `count` on the very next cycle. It also bends the pin waveform, because every pin level is a comparison against that count. A buffer that reloads at the wrong point stays hidden until the first period after a mid-period write, and then shifts a pin edge by up to a full period. A stuck or late flag shows on `ovf_flag` one cycle after the wrap or bottom edge. An override mask that is stored wrongly shows as a pin that follows the waveform where it should show its port bit.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    MD_COUNT,
    MD_FAST,
    MD_DUAL,
    MD_SIX_SS,
    MD_SIX_DS
  } tmode_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_TOP  = 1;
  localparam int ADR_OE   = 2;
  localparam int ADR_PORT = 3;
  localparam int ADR_FLAG = 4;
  localparam int ADR_CMP0 = 5;

  function automatic tmode_e decode_mode(input logic en, input logic [1:0] field);
    if (!en) return MD_COUNT;
    case (field)
      2'b00:   return MD_FAST;
      2'b01:   return MD_DUAL;
      2'b10:   return MD_SIX_SS;
      default: return MD_SIX_DS;
    endcase
  endfunction

  function automatic logic is_dual(input tmode_e m);
    return (m == MD_DUAL) || (m == MD_SIX_DS);
  endfunction

  function automatic logic is_six(input tmode_e m);
    return (m == MD_SIX_SS) || (m == MD_SIX_DS);
  endfunction

endpackage

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          period_evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic up;

  // end of period: wrap for single slope, leaving zero for dual slope
  assign period_evt = dual ? (cnt == '0) : (cnt >= top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!dual) begin
      up  <= 1'b1;
      cnt <= (cnt >= top) ? '0 : cnt + ONE;
    end else if (cnt == '0) begin
      up  <= 1'b1;
      cnt <= (top != '0) ? ONE : '0;
    end else if (up && (cnt >= top)) begin
      up  <= 1'b0;
      cnt <= cnt - ONE;
    end else begin
      cnt <= up ? cnt + ONE : cnt - ONE;
    end
  end
endmodule

// File: rtl/ptc_buffer.sv
module ptc_buffer #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter logic [AW-1:0] ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          load,
  input  logic          bypass,
  output logic [W-1:0]  buf_q,
  output logic [W-1:0]  eff
);
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en && (wr_addr == ADDR)) buf_q <= wr_data;
      if (load) act_q <= buf_q;
    end
  end

  assign eff = bypass ? buf_q : act_q;
endmodule

// File: rtl/ptc_pinmux.sv
module ptc_pinmux
  import pwm_timer_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCMP = 3,
  localparam int NPIN = 2 * NCMP
) (
  input  tmode_e                   mode,
  input  logic [CW-1:0]            cnt,
  input  logic [NCMP-1:0][CW-1:0]  cmp,
  input  logic [NPIN-1:0]          oe,
  input  logic [NPIN-1:0]          port,
  output logic [NPIN-1:0]          pins
);
  logic [NCMP-1:0] wave;

  always_comb begin
    for (int k = 0; k < NCMP; k++) wave[k] = (cnt < cmp[k]);
    pins = port;
    if (is_six(mode)) begin
      for (int i = 0; i < NPIN; i++) pins[i] = oe[i] ? wave[0] : port[i];
    end else if (mode != MD_COUNT) begin
      for (int k = 0; k < NCMP; k++) begin
        pins[2*k]   = wave[k];
        pins[2*k+1] = ~wave[k];
      end
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCMP = 3,
  parameter int AW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic [CW-1:0]     count,
  output logic              ovf_flag,
  output logic [2*NCMP-1:0] pins
);
  localparam int NPIN = 2 * NCMP;

  logic                   ctrl_en;
  logic [1:0]             ctrl_field;
  logic [NPIN-1:0]        oe_q;
  logic [NPIN-1:0]        port_q;
  tmode_e                 mode;
  logic                   normal;
  logic                   dual;
  logic                   period_evt;
  logic                   load;
  logic [CW-1:0]          top_buf;
  logic [CW-1:0]          top_eff;
  logic [NCMP-1:0][CW-1:0] cmp_buf;
  logic [NCMP-1:0][CW-1:0] cmp_eff;

  assign mode   = decode_mode(ctrl_en, ctrl_field);
  assign normal = (mode == MD_COUNT);
  assign dual   = is_dual(mode);
  assign load   = normal | period_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_field <= 2'b00;
      oe_q       <= '0;
      port_q     <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL)) {ctrl_en, ctrl_field} <= wr_data[2:0];
      if (wr_addr == AW'(ADR_OE))   oe_q   <= wr_data[NPIN-1:0];
      if (wr_addr == AW'(ADR_PORT)) port_q <= wr_data[NPIN-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else if (period_evt) ovf_flag <= 1'b1;
    else if (wr_en && (wr_addr == AW'(ADR_FLAG)) && wr_data[0]) ovf_flag <= 1'b0;
  end

  ptc_buffer #(.W(CW), .AW(AW), .ADDR(AW'(ADR_TOP))) u_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .bypass(normal), .buf_q(top_buf), .eff(top_eff)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    ptc_buffer #(.W(CW), .AW(AW), .ADDR(AW'(ADR_CMP0 + g))) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(load), .bypass(normal), .buf_q(cmp_buf[g]), .eff(cmp_eff[g])
    );
  end

  ptc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dual(dual), .top(top_eff),
    .cnt(count), .period_evt(period_evt)
  );

  ptc_pinmux #(.CW(CW), .NCMP(NCMP)) u_mux (
    .mode(mode), .cnt(count), .cmp(cmp_eff), .oe(oe_q), .port(port_q), .pins(pins)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADR_CTRL)) rd_data = CW'({ctrl_en, ctrl_field});
    if (rd_addr == AW'(ADR_TOP))  rd_data = top_buf;
    if (rd_addr == AW'(ADR_OE))   rd_data = CW'(oe_q);
    if (rd_addr == AW'(ADR_PORT)) rd_data = CW'(port_q);
    if (rd_addr == AW'(ADR_FLAG)) rd_data = CW'(ovf_flag);
    for (int k = 0; k < NCMP; k++)
      if (rd_addr == AW'(ADR_CMP0 + k)) rd_data = cmp_buf[k];
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import pwm_timer_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCMP = 3,
  parameter int AW   = 3,
  localparam int NPIN = 2 * NCMP
) (
  input logic                    clk,
  input logic                    rst_n,
  input tmode_e                  mode,
  input logic [CW-1:0]           cnt,
  input logic                    evt,
  input logic                    flag,
  input logic [NPIN-1:0]         pins,
  input logic [NPIN-1:0]         port_q,
  input logic [NPIN-1:0]         oe_q,
  input logic [AW-1:0]           rd_addr,
  input logic [CW-1:0]           rd_data,
  input logic [NCMP-1:0][CW-1:0] cmp_eff,
  input logic [CW-1:0]           top_eff
);
  assert_count_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_COUNT) |-> (pins == port_q));

  assert_single_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_dual(mode) && (cnt >= top_eff)) |=> (cnt == '0));

  assert_dual_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual(mode) && (cnt == '0) && (top_eff != '0)) |=> (cnt == CW'(1)));

  assert_fast_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_FAST) && !evt) ##1 (mode == MD_FAST) |-> $stable(cmp_eff));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  assert_six_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_six(mode) |-> (((pins ^ port_q) & ~oe_q) == '0));

  assert_oe_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(ADR_OE)) |-> (rd_data[CW-1:NPIN] == '0));
endmodule

bind pwm_timer ptc_checker #(.CW(CW), .NCMP(NCMP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cnt(count), .evt(period_evt),
  .flag(ovf_flag), .pins(pins), .port_q(port_q), .oe_q(oe_q),
  .rd_addr(rd_addr), .rd_data(rd_data), .cmp_eff(cmp_eff), .top_eff(top_eff)
);

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] count;
  logic       ovf_flag;
  logic [5:0] pins;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int m_en = 0, m_f = 0, m_cnt = 0, m_up = 1, m_flag = 0;
  int m_tbuf = 0, m_tact = 0, m_oe = 0, m_port = 0;
  int m_cbuf[3] = '{0, 0, 0};
  int m_cact[3] = '{0, 0, 0};

  pwm_timer uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic model_step(input bit we, input int a, input int d);
    bit normal = (m_en == 0);
    bit dual = (m_en != 0) && (m_f % 2 == 1);
    int te = normal ? m_tbuf : m_tact;
    bit evt = dual ? (m_cnt == 0) : (m_cnt >= te);
    int nc;
    if (!dual) begin
      nc = (m_cnt >= te) ? 0 : m_cnt + 1;
      m_up = 1;
    end else if (m_cnt == 0) begin
      nc = (te > 0) ? 1 : 0;
      m_up = 1;
    end else if (m_up == 1 && m_cnt >= te) begin
      nc = m_cnt - 1;
      m_up = 0;
    end else begin
      nc = (m_up == 1) ? m_cnt + 1 : m_cnt - 1;
    end
    if (normal || evt) begin
      m_tact = m_tbuf;
      for (int k = 0; k < 3; k++) m_cact[k] = m_cbuf[k];
    end
    if (evt) m_flag = 1;
    else if (we && a == 4 && (d % 2 == 1)) m_flag = 0;
    if (we) begin
      case (a)
        0: begin m_en = (d / 4) % 2; m_f = d % 4; end
        1: m_tbuf = d;
        2: m_oe = d % 64;
        3: m_port = d % 64;
        5, 6, 7: m_cbuf[a-5] = d;
        default: ;
      endcase
    end
    m_cnt = nc;
  endtask

  task automatic compare();
    int exp_pins = 0;
    bit six = (m_en != 0) && (m_f >= 2);
    bit dual = (m_en != 0) && (m_f % 2 == 1);
    string ptag;
    for (int i = 0; i < 6; i++) begin
      int pb = (m_port >> i) % 2;
      int bitv;
      if (m_en == 0) bitv = pb;
      else if (six) bitv = ((m_oe >> i) % 2 == 1) ? int'(m_cnt < m_cact[0]) : pb;
      else begin
        int w = int'(m_cnt < m_cact[i/2]);
        bitv = (i % 2 == 1) ? 1 - w : w;
      end
      exp_pins += bitv << i;
    end
    ptag = (m_en == 0) ? "R1" : (six ? "R8" : "R7");
    chk(dual ? "R4 count" : "R3 count", int'(count), m_cnt);
    chk("R6 flag", int'(ovf_flag), m_flag);
    chk({ptag, " pins"}, int'(pins), exp_pins);
  endtask

  task automatic cyc(input bit we, input int a, input int d);
    wr_en = we;
    wr_addr = 3'(a);
    wr_data = 8'(d);
    @(posedge clk);
    model_step(we, a, d);
    #2;
    compare();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R10: reset state
    chk("R10 count", int'(count), 0);
    chk("R10 flag", int'(ovf_flag), 0);
    chk("R10 pins", int'(pins), 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk("R10 read", int'(rd_data), 0);
    end

    // R1/R3: plain counter, mode field ignored while enable is clear
    cyc(1, 3, 8'h2A);
    cyc(1, 1, 5);
    cyc(1, 5, 3);
    run(14);
    cyc(1, 0, 3);
    run(10);
    cyc(1, 4, 1);
    run(3);

    // R2/R5/R7: single-slope PWM with mid-period updates
    cyc(1, 0, 4);
    cyc(1, 6, 0);
    cyc(1, 7, 9);
    run(12);
    cyc(1, 5, 1);
    cyc(1, 1, 7);
    run(20);

    // R4/R5/R7: dual-slope PWM
    cyc(1, 0, 5);
    run(6);
    cyc(1, 5, 4);
    cyc(1, 1, 4);
    run(24);
    cyc(1, 1, 0);
    run(12);
    cyc(1, 1, 3);
    cyc(1, 4, 1);
    run(14);

    // R8: six-pin single-slope with mask changes
    cyc(1, 0, 6);
    cyc(1, 2, 8'h33);
    cyc(1, 5, 2);
    run(12);
    cyc(1, 2, 8'h0C);
    run(8);
    cyc(1, 3, 8'h15);
    run(6);

    // R8/R4: six-pin dual-slope
    cyc(1, 0, 7);
    cyc(1, 2, 8'h3F);
    run(16);
    cyc(1, 2, 8'h00);
    run(6);

    // R9: reserved override bits read as zero
    cyc(1, 2, 8'hFF);
    rd_addr = 3'd2;
    #1;
    chk("R9 override readback", int'(rd_data), 8'h3F);
    run(4);

    // R6: clear while events continue, then read flag register
    cyc(1, 4, 1);
    rd_addr = 3'd4;
    #1;
    chk("R6 flag read", int'(rd_data), m_flag);
    run(10);

    done = 1;
    summary();
    $finish;
  end
endmodule